// File: doc/BRIEF.md
# LIN Synchronisation Field Edge Timestamper

This block measures the bit rate of an incoming LIN frame. After the break detector signals a break, the block watches the receive line for the falling edges of the synchronisation byte (0x55). It stamps the value of a free-running timer on the first of those edges and again on the fifth. Software subtracts the two stamps to get the length of eight bit times. Each stamp raises its own interrupt request, and each request is gated by a per-channel enable.

The receive line first passes through a two-flop synchroniser. A falling edge is taken from the synchronised samples. A small state machine counts the edges. Its states are ST_IDLE (disarmed), ST_WAIT_FIRST (armed after a break, waiting for the first edge) and ST_COUNT (first edge taken, counting up to the fifth). It has these transitions:
- break → ST_WAIT_FIRST from any state;
- first edge → ST_COUNT, with the first stamp taken;
- fifth edge → ST_IDLE, with the second stamp taken;
- operating mode other than LIN → ST_IDLE.

Edges in ST_IDLE are ignored. The block works only in the LIN operating mode, which is encoded as `op_mode == 2'b11`. An interrupt request is cleared by driving its enable low for at least one cycle.

Top module: `lin_sync_capture`

## Requirements
- R1: After reset, `cap_first`, `cap_last`, `irq_first` and `irq_last` are all zero and the block is disarmed.
- R2: On the first falling edge after a break, `cap_first` loads the timer value. The timer value used is the one present at the clock edge two cycles after the first cycle in which `rx_line` is sampled low following a high sample.
- R3: On the fifth falling edge after a break, `cap_last` loads the timer value in the same way. For a 0x55 byte sent LSB first with start and stop bits, `cap_last - cap_first` (modulo 2^16) equals eight bit periods in clock cycles.
- R4: Edges two to four change neither capture register. After the fifth edge the block disarms, and further edges change nothing until the next break.
- R5: Falling edges on the line with no preceding break are ignored.
- R6: When `op_mode` is not 2'b11, both `brk_strobe` and edges are ignored. Leaving 2'b11 in the middle of a sequence disarms the block, and returning to 2'b11 does not re-arm it.
- R7: Capture interrupt behaviour:
  - `irq_first` is set by a first-edge capture only while `cap_en[0]` is 1.
  - `irq_last` is set by a fifth-edge capture only while `cap_en[1]` is 1.
  - Each request holds until its enable is 0 at a clock edge, which clears it in the next cycle.
  - Captures load regardless of the enables.
- R8: The timer advances by one each cycle and wraps. While `timer_clr` is 1 at a clock edge, the timer is zero in the next cycle.
- R9: A break in the middle of a sequence restarts the edge count, so the next falling edge is treated as the first.
- R10: Each high-to-low transition of the synchronised line is recognised exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous LIN receive line |
| brk_strobe | input | 1 | One-cycle pulse: break detected |
| op_mode | input | 2 | Operating mode; 2'b11 is LIN mode |
| cap_en | input | 2 | Bit 0 enables the first-edge request, bit 1 enables the fifth-edge request |
| timer_clr | input | 1 | Zeroes the free-running timer |
| cap_first | output | TIMER_W | Timer stamp of the first sync edge |
| cap_last | output | TIMER_W | Timer stamp of the fifth sync edge |
| irq_first | output | 1 | Interrupt request for the first-edge capture |
| irq_last | output | 1 | Interrupt request for the fifth-edge capture |

## Verification
The bench drives complete sync bytes at several bit periods, which separates a correct eight-bit-time span from an off-by-one edge ordinal. It also drives edges with no prior break and extra edges after the fifth, which separates a properly disarming counter from one that keeps capturing. Aborted sequences are covered by:
- a second break in mid-count, which tells a restarting count from a continuing one;
- a mode drop in mid-count, which tells a real disarm from a pause.

Enable masking and clearing, and a timer held in clear during a whole byte, show that the stamps and requests follow their own controls.

// File: rtl/lin_cap_pkg.sv
package lin_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_FIRST = 2'd1,
        ST_COUNT      = 2'd2
    } cap_state_e;

    localparam logic [1:0] MODE_LIN = 2'b11;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic fall_pulse
);
    // pipe[STAGES-1] is the synchronised line, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], rx_line};
    end

    assign fall_pulse = pipe[STAGES] & ~pipe[STAGES-1];

    // R10
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/lin_free_timer.sv
module lin_free_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end

    // R8
    timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
    // R8
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/lin_edge_fsm.sv
module lin_edge_fsm
    import lin_cap_pkg::*;
#(
    parameter int TW        = 16,
    parameter int EDGE_LAST = 5,
    localparam int CW       = $clog2(EDGE_LAST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lin_mode,
    input  logic          brk,
    input  logic          fall,
    input  logic [TW-1:0] timer,
    input  logic [1:0]    en,
    output logic [TW-1:0] cap_first,
    output logic [TW-1:0] cap_last,
    output logic          irq_first,
    output logic          irq_last
);
    cap_state_e    state, nxt;
    logic [CW-1:0] edge_cnt, cnt_nxt;
    logic          take_first, take_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            edge_cnt <= '0;
        end else begin
            state    <= nxt;
            edge_cnt <= cnt_nxt;
        end
    end

    always_comb begin
        nxt        = state;
        cnt_nxt    = edge_cnt;
        take_first = 1'b0;
        take_last  = 1'b0;
        if (!lin_mode) begin
            nxt     = ST_IDLE;
            cnt_nxt = '0;
        end else if (brk) begin
            nxt     = ST_WAIT_FIRST;
            cnt_nxt = '0;
        end else if (fall) begin
            unique case (state)
                ST_IDLE: begin
                    nxt = ST_IDLE;
                end
                ST_WAIT_FIRST: begin
                    take_first = 1'b1;
                    cnt_nxt    = CW'(1);
                    nxt        = ST_COUNT;
                end
                ST_COUNT: begin
                    cnt_nxt = edge_cnt + 1'b1;
                    if (cnt_nxt == CW'(EDGE_LAST)) begin
                        take_last = 1'b1;
                        cnt_nxt   = '0;
                        nxt       = ST_IDLE;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_first <= '0;
            cap_last  <= '0;
            irq_first <= 1'b0;
            irq_last  <= 1'b0;
        end else begin
            if (take_first) cap_first <= timer;
            if (take_last)  cap_last  <= timer;
            irq_first <= en[0] & (irq_first | take_first);
            irq_last  <= en[1] & (irq_last  | take_last);
        end
    end

    // R6
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_mode |=> state == ST_IDLE);
    // R2
    first_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && !brk && fall && state == ST_WAIT_FIRST) |=> cap_first == $past(timer));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(cap_first) && $stable(cap_last));
    // R7
    first_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[0] |=> !irq_first);
    // R7
    last_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[1] |=> !irq_last);
    // R3
    last_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_last) |-> $past(state) == ST_COUNT);
endmodule

// File: rtl/lin_sync_capture.sv
module lin_sync_capture
    import lin_cap_pkg::*;
#(
    parameter int TIMER_W   = 16,
    parameter int SYNC_FF   = 2,
    parameter int EDGE_LAST = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_line,
    input  logic               brk_strobe,
    input  logic [1:0]         op_mode,
    input  logic [1:0]         cap_en,
    input  logic               timer_clr,
    output logic [TIMER_W-1:0] cap_first,
    output logic [TIMER_W-1:0] cap_last,
    output logic               irq_first,
    output logic               irq_last
);
    logic               fall;
    logic [TIMER_W-1:0] timer;
    logic               lin_mode;

    assign lin_mode = (op_mode == MODE_LIN);

    lin_rx_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .fall_pulse (fall)
    );

    lin_free_timer #(.W(TIMER_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .count (timer)
    );

    lin_edge_fsm #(.TW(TIMER_W), .EDGE_LAST(EDGE_LAST)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lin_mode  (lin_mode),
        .brk       (brk_strobe),
        .fall      (fall),
        .timer     (timer),
        .en        (cap_en),
        .cap_first (cap_first),
        .cap_last  (cap_last),
        .irq_first (irq_first),
        .irq_last  (irq_last)
    );
endmodule

// File: tb/tb_lin_sync_capture.sv
`timescale 1ns/1ps
module tb_lin_sync_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        brk_strobe = 1'b0;
    logic [1:0]  op_mode = 2'b11;
    logic [1:0]  cap_en = 2'b11;
    logic        timer_clr = 1'b0;
    logic [15:0] cap_first, cap_last;
    logic        irq_first, irq_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lin_sync_capture dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .brk_strobe(brk_strobe),
        .op_mode(op_mode), .cap_en(cap_en), .timer_clr(timer_clr),
        .cap_first(cap_first), .cap_last(cap_last),
        .irq_first(irq_first), .irq_last(irq_last)
    );

    // Behavioural reference: line history, armed flag and edge ordinal
    int  m_hist[$];
    int  m_tmr, m_c1, m_c5, m_ord;
    bit  m_armed, m_i1, m_i5;

    always @(posedge clk) begin
        bit ev1, ev5, fell;
        ev1 = 0; ev5 = 0;
        if (!rst_n) begin
            m_hist = '{1, 1, 1};
            m_tmr = 0; m_c1 = 0; m_c5 = 0; m_ord = 0;
            m_armed = 0; m_i1 = 0; m_i5 = 0;
        end else begin
            // oldest two entries are the synchronised line, one cycle apart
            fell = (m_hist[0] == 1) && (m_hist[1] == 0);
            if (op_mode != 2'b11) begin
                m_armed = 0; m_ord = 0;
            end else if (brk_strobe) begin
                m_armed = 1; m_ord = 0;
            end else if (fell && m_armed) begin
                m_ord++;
                if (m_ord == 1) begin m_c1 = m_tmr; ev1 = 1; end
                if (m_ord == 5) begin m_c5 = m_tmr; ev5 = 1; m_armed = 0; end
            end
            m_i1 = cap_en[0] && (m_i1 || ev1);
            m_i5 = cap_en[1] && (m_i5 || ev5);
            m_tmr = timer_clr ? 0 : (m_tmr + 1) % 65536;
            void'(m_hist.pop_front());
            m_hist.push_back(int'(rx_line));
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cap_first == 16'(m_c1), "R2 cap_first", int'(cap_first), m_c1);
            chk(cap_last  == 16'(m_c5), "R3 cap_last",  int'(cap_last),  m_c5);
            chk(irq_first == m_i1, "R7 irq_first", int'(irq_first), int'(m_i1));
            chk(irq_last  == m_i5, "R7 irq_last",  int'(irq_last),  int'(m_i5));
        end
    end

    task automatic put_bit(bit v, int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_brk();
        put_bit(0, 20);
        put_bit(1, 4);
        brk_strobe = 1'b1;
        @(negedge clk);
        brk_strobe = 1'b0;
    endtask

    // 0x55 LSB first: start 0, then 1,0,1,0,1,0,1,0, stop 1
    task automatic send_sync(int bitc);
        for (int i = 0; i < 9; i++) put_bit(i % 2 == 1, bitc);
        put_bit(1, bitc);
        put_bit(1, 6);
    endtask

    task automatic chk_span(int bitc, string req);
        int d;
        d = int'(16'(cap_last - cap_first));
        chk(d == 8 * bitc, req, d, 8 * bitc);
    endtask

    initial begin
        logic [15:0] s1, s5;
        repeat (3) @(negedge clk);
        chk(cap_first == 0 && cap_last == 0, "R1 captures", int'(cap_first), 0);
        chk(!irq_first && !irq_last, "R1 irqs", int'(irq_first), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: sync without break
        send_sync(8);
        chk(cap_first == 0 && cap_last == 0, "R5 no capture", int'(cap_last), 0);

        // R2 R3: full sequence
        send_brk();
        send_sync(10);
        chk_span(10, "R3 span 10");
        chk(irq_first && irq_last, "R7 both raised", int'({irq_first, irq_last}), 3);

        // R4: edges after the fifth ignored
        s1 = cap_first; s5 = cap_last;
        for (int k = 0; k < 4; k++) begin put_bit(0, 5); put_bit(1, 5); end
        repeat (4) @(negedge clk);
        chk(cap_first == s1 && cap_last == s5, "R4 disarmed", int'(cap_last), int'(s5));

        // R7: disable clears
        cap_en = 2'b00;
        @(negedge clk);
        cap_en = 2'b11;
        @(negedge clk);
        chk(!irq_first && !irq_last, "R7 cleared", int'({irq_first, irq_last}), 0);

        // R7: only first enabled
        cap_en = 2'b01;
        send_brk();
        send_sync(7);
        chk(irq_first && !irq_last, "R7 masked last", int'({irq_first, irq_last}), 2);
        chk_span(7, "R3 span 7");
        cap_en = 2'b11;

        // R6: non-LIN mode ignores break and edges
        op_mode = 2'b10;
        s1 = cap_first; s5 = cap_last;
        send_brk();
        send_sync(9);
        chk(cap_first == s1 && cap_last == s5, "R6 mode gated", int'(cap_first), int'(s1));
        op_mode = 2'b11;

        // R9: break in mid-count restarts
        send_brk();
        for (int k = 0; k < 3; k++) begin put_bit(0, 6); put_bit(1, 6); end
        send_brk();
        send_sync(6);
        chk_span(6, "R9 restart span");

        // R6: mode drop disarms
        s1 = cap_first; s5 = cap_last;
        send_brk();
        for (int k = 0; k < 2; k++) begin put_bit(0, 5); put_bit(1, 5); end
        op_mode = 2'b00;
        repeat (3) @(negedge clk);
        op_mode = 2'b11;
        send_sync(5);
        chk(cap_last == s5, "R6 disarmed by mode", int'(cap_last), int'(s5));

        // R8: timer clear pulse, then timer held clear for a whole byte
        timer_clr = 1'b1;
        @(negedge clk);
        timer_clr = 1'b0;
        send_brk();
        send_sync(12);
        chk_span(12, "R8 span after clear");
        send_brk();
        timer_clr = 1'b1;
        send_sync(4);
        timer_clr = 1'b0;
        chk(cap_first == 0 && cap_last == 0, "R8 held clear", int'(cap_last), 0);

        // R10: short pulses still count as single edges
        send_brk();
        send_sync(3);
        chk_span(3, "R10 short bits");

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule